// File: doc/BRIEF.md
# Time-Slotted Frame Buffer Arbiter

This block shares one frame buffer memory, 64 bits wide and built from two 32-bit banks accessed in the same cycle, between three clients: a video scanner, a host bus port and an image warper. The memory runs at the processor clock of about 40 MHz. The scanner has to fetch one 64-bit word (two pixels) every second cycle, which gives a 20 MHz pixel-pair rate. A memory of half this width at the same clock could not meet that rate and still leave room for the other clients.

A one-bit slot phase toggles on every cycle. In the scanner slot the memory belongs only to the scanner. It is never delayed and never lent to anyone else. In the shared slot, host and warper compete. When both are asking, they are served in round-robin order. Every client uses a request/ready handshake. A client holds its request, address and write data until it sees ready. Write enables are per 32-bit lane, so one pixel can be written without disturbing its neighbour. Read data comes back exactly one cycle after the grant, on the port of the client that was granted.

Top module: `fb_slot_arbiter`

## Requirements
- R1: While reset is asserted, no ready is given and the memory is idle. The first cycle after reset is released is a scanner slot (`scan_slot` high), and no read-valid output is high.
- R2: After reset, `scan_slot` alternates on every clock cycle.
- R3: In a scanner slot with `scan_req` high, `scan_rdy` is high in the same cycle. The memory is enabled for a read (`mem_we` all zero) at `scan_addr`.
- R4: In a scanner slot, host and warper never get ready, even when the scanner is not requesting. With no scanner request, `mem_en` is low.
- R5: In a shared slot with a single requester, that requester gets ready in that cycle. Its address drives `mem_addr`.
- R6: When host and warper both request in a shared slot, the one not granted last time wins. The host wins the first such contest after reset. At most one ready is high per cycle.
- R7: A granted write drives `mem_we[i]` from byte-lane enable `be[i]`. Lane 0 is data bits 31:0 and lane 1 is bits 63:32. A lane whose enable is 0 keeps its previous memory content.
- R8: A granted host or warper read raises that port's `rvalid` exactly one cycle after ready, with the memory word on its `rdata`. The other port's `rvalid` stays low. `rdata` is zero when `rvalid` is low.
- R9: A scanner grant raises `scan_rvalid` one cycle later, with the word read from `scan_addr` on `scan_rdata`.
- R10: In a shared slot with no request, `mem_en` is low.
- R11: A granted write never raises `rvalid` on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory/processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_slot | output | 1 | High in the cycle reserved for the scanner |
| scan_req | input | 1 | Scanner read request |
| scan_addr | input | ADDR_W | Scanner word address |
| scan_rdy | output | 1 | Scanner request accepted |
| scan_rvalid | output | 1 | Scanner read data valid |
| scan_rdata | output | DATA_W | Scanner read data |
| host_req | input | 1 | Host request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_be | input | LANES | Host per-lane write enables |
| host_rdy | output | 1 | Host request accepted |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | DATA_W | Host read data |
| warp_req | input | 1 | Warper request |
| warp_we | input | 1 | Warper write (1) or read (0) |
| warp_addr | input | ADDR_W | Warper word address |
| warp_wdata | input | DATA_W | Warper write data |
| warp_be | input | LANES | Warper per-lane write enables |
| warp_rdy | output | 1 | Warper request accepted |
| warp_rvalid | output | 1 | Warper read data valid |
| warp_rdata | output | DATA_W | Warper read data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | LANES | Per-lane memory write enables |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the access |

## Verification
The bench keeps host and warper waiting across scanner slots. A design that lent an idle scanner slot to the shared port would hand out ready one cycle early and break the scanner bandwidth guarantee. Back-to-back contests check that the winner alternates, and that the host wins first after reset. A pointer that never updated, or updated on a lost contest, would starve the warper. A host write with only the upper lane enabled is read back later. A design that ignored the lane enables would overwrite the lower pixel. Each read is checked on the cycle after its grant and on both ports. A design with a two-cycle return, a missing tag, or a valid raised for a write would put data on the wrong port or in the wrong cycle.

// File: rtl/fbarb_pkg.sv
package fbarb_pkg;

  // Which reads are in flight toward the ports on the next cycle.
  typedef struct packed {
    logic scan;
    logic host;
    logic warp;
  } rtag_t;

  // Shared-slot decision. Returns {warp_win, host_win}.
  // last_warp = 1 means the warper won the previous shared grant.
  function automatic logic [1:0] pick_shared(input logic hreq,
                                             input logic wreq,
                                             input logic last_warp);
    logic [1:0] win;
    win = 2'b00;
    if (hreq && wreq) win = last_warp ? 2'b01 : 2'b10;
    else if (hreq)    win = 2'b01;
    else if (wreq)    win = 2'b10;
    return win;
  endfunction

endpackage

// File: rtl/fbarb_phase.sv
module fbarb_phase (
  input  logic clk,
  input  logic rst_n,
  output logic scan_slot
);
  logic phase_q;  // 0: scanner slot, 1: shared slot

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign scan_slot = ~phase_q;
endmodule

// File: rtl/fbarb_rr.sv
module fbarb_rr
  import fbarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shared_slot,
  input  logic host_req,
  input  logic warp_req,
  output logic host_gnt,
  output logic warp_gnt
);
  logic       last_warp_q;
  logic [1:0] win;

  always_comb begin
    win      = pick_shared(host_req, warp_req, last_warp_q);
    host_gnt = shared_slot & win[0];
    warp_gnt = shared_slot & win[1];
  end

  // The pointer moves only when a grant is actually given.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_warp_q <= 1'b1;  // host first after reset
    else if (host_gnt) last_warp_q <= 1'b0;
    else if (warp_gnt) last_warp_q <= 1'b1;
  end
endmodule

// File: rtl/fbarb_mux.sv
module fbarb_mux #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 64,
  parameter int LANES  = 2
) (
  input  logic              scan_gnt,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic              host_gnt,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  input  logic              warp_gnt,
  input  logic              warp_we,
  input  logic [ADDR_W-1:0] warp_addr,
  input  logic [DATA_W-1:0] warp_wdata,
  input  logic [LANES-1:0]  warp_be,
  output logic              mem_en,
  output logic [LANES-1:0]  mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic host_wr, warp_wr;

  assign host_wr = host_gnt & host_we;
  assign warp_wr = warp_gnt & warp_we;
  assign mem_en  = scan_gnt | host_gnt | warp_gnt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_we
    assign mem_we[l] = (host_wr & host_be[l]) | (warp_wr & warp_be[l]);
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (scan_gnt) begin
      mem_addr = scan_addr;
    end else if (host_gnt) begin
      mem_addr  = host_addr;
      mem_wdata = host_wr ? host_wdata : '0;
    end else if (warp_gnt) begin
      mem_addr  = warp_addr;
      mem_wdata = warp_wr ? warp_wdata : '0;
    end
  end
endmodule

// File: rtl/fbarb_rsteer.sv
module fbarb_rsteer
  import fbarb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_gnt,
  input  logic              host_gnt,
  input  logic              host_we,
  input  logic              warp_gnt,
  input  logic              warp_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              scan_rvalid,
  output logic [DATA_W-1:0] scan_rdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              warp_rvalid,
  output logic [DATA_W-1:0] warp_rdata
);
  rtag_t tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else begin
      tag_q.scan <= scan_gnt;
      tag_q.host <= host_gnt & ~host_we;
      tag_q.warp <= warp_gnt & ~warp_we;
    end
  end

  assign scan_rvalid = tag_q.scan;
  assign host_rvalid = tag_q.host;
  assign warp_rvalid = tag_q.warp;
  assign scan_rdata  = tag_q.scan ? mem_rdata : '0;
  assign host_rdata  = tag_q.host ? mem_rdata : '0;
  assign warp_rdata  = tag_q.warp ? mem_rdata : '0;
endmodule

// File: rtl/fb_slot_arbiter.sv
module fb_slot_arbiter #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 64,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              scan_slot,
  input  logic              scan_req,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic              scan_rdy,
  output logic              scan_rvalid,
  output logic [DATA_W-1:0] scan_rdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  output logic              host_rdy,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              warp_req,
  input  logic              warp_we,
  input  logic [ADDR_W-1:0] warp_addr,
  input  logic [DATA_W-1:0] warp_wdata,
  input  logic [LANES-1:0]  warp_be,
  output logic              warp_rdy,
  output logic              warp_rvalid,
  output logic [DATA_W-1:0] warp_rdata,
  output logic              mem_en,
  output logic [LANES-1:0]  mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  // Named internal events, visible to the bound checker.
  logic slot_raw;
  logic shared_slot;
  logic scan_gnt, host_gnt, warp_gnt;

  fbarb_phase i_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_slot (slot_raw)
  );

  assign scan_slot   = slot_raw;
  assign shared_slot = rst_n & ~slot_raw;
  assign scan_gnt    = rst_n & slot_raw & scan_req;

  fbarb_rr i_rr (
    .clk         (clk),
    .rst_n       (rst_n),
    .shared_slot (shared_slot),
    .host_req    (host_req),
    .warp_req    (warp_req),
    .host_gnt    (host_gnt),
    .warp_gnt    (warp_gnt)
  );

  assign scan_rdy = scan_gnt;
  assign host_rdy = host_gnt;
  assign warp_rdy = warp_gnt;

  fbarb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_mux (
    .scan_gnt   (scan_gnt),
    .scan_addr  (scan_addr),
    .host_gnt   (host_gnt),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_be    (host_be),
    .warp_gnt   (warp_gnt),
    .warp_we    (warp_we),
    .warp_addr  (warp_addr),
    .warp_wdata (warp_wdata),
    .warp_be    (warp_be),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  fbarb_rsteer #(.DATA_W(DATA_W)) i_rsteer (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_gnt    (scan_gnt),
    .host_gnt    (host_gnt),
    .host_we     (host_we),
    .warp_gnt    (warp_gnt),
    .warp_we     (warp_we),
    .mem_rdata   (mem_rdata),
    .scan_rvalid (scan_rvalid),
    .scan_rdata  (scan_rdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .warp_rvalid (warp_rvalid),
    .warp_rdata  (warp_rdata)
  );
endmodule

// File: rtl/fbarb_checker.sv
module fbarb_checker #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_slot,
  input logic              scan_req,
  input logic [ADDR_W-1:0] scan_addr,
  input logic              scan_rdy,
  input logic              scan_rvalid,
  input logic              host_req,
  input logic              host_we,
  input logic [LANES-1:0]  host_be,
  input logic              host_rdy,
  input logic              host_rvalid,
  input logic              warp_req,
  input logic              warp_we,
  input logic              warp_rdy,
  input logic              warp_rvalid,
  input logic              mem_en,
  input logic [LANES-1:0]  mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !scan_rdy && !host_rdy && !warp_rdy && !mem_en); // R1
  AST_SLOT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n) scan_slot |=> !scan_slot); // R2
  AST_SLOT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) !scan_slot |=> scan_slot); // R2
  AST_SCAN_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    scan_slot && scan_req |-> scan_rdy && mem_en && mem_we == '0 && mem_addr == scan_addr); // R3
  AST_SCAN_SLOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n) scan_slot |-> !host_rdy && !warp_rdy); // R4
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({scan_rdy, host_rdy, warp_rdy})); // R6
  AST_RR_TO_WARP: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_slot && host_rdy && warp_req) ##2 (host_req && warp_req) |-> warp_rdy); // R6
  AST_RR_TO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_slot && warp_rdy && host_req) ##2 (host_req && warp_req) |-> host_rdy); // R6
  AST_LANE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) host_rdy && host_we |-> mem_we == host_be); // R7
  AST_HOST_RETURN: assert property (@(posedge clk) disable iff (!rst_n) host_rdy && !host_we |=> host_rvalid && !warp_rvalid); // R8
  AST_WARP_RETURN: assert property (@(posedge clk) disable iff (!rst_n) warp_rdy && !warp_we |=> warp_rvalid && !host_rvalid); // R8
  AST_SCAN_RETURN: assert property (@(posedge clk) disable iff (!rst_n) scan_rdy |=> scan_rvalid); // R9
  AST_IDLE_MEM: assert property (@(posedge clk) disable iff (!rst_n) !scan_rdy && !host_rdy && !warp_rdy |-> !mem_en); // R10
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdy && host_we) || (warp_rdy && warp_we) |=> !host_rvalid && !warp_rvalid); // R11
endmodule

bind fb_slot_arbiter fbarb_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) i_fbarb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_slot   (scan_slot),
  .scan_req    (scan_req),
  .scan_addr   (scan_addr),
  .scan_rdy    (scan_rdy),
  .scan_rvalid (scan_rvalid),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_be     (host_be),
  .host_rdy    (host_rdy),
  .host_rvalid (host_rvalid),
  .warp_req    (warp_req),
  .warp_we     (warp_we),
  .warp_rdy    (warp_rdy),
  .warp_rvalid (warp_rvalid),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr)
);

// File: tb/test_fb_slot_arbiter.sv
`timescale 1ns/100ps
module test_fb_slot_arbiter;
  localparam int AW = 18;
  localparam int DW = 64;
  localparam int LN = 2;
  localparam logic [AW-1:0] HOST_A = 18'd3;
  localparam logic [AW-1:0] WARP_A = 18'd5;
  localparam logic [DW-1:0] HOST_D = 64'hABCD_1111_1234_5555;
  localparam logic [DW-1:0] WARP_D = 64'h7777_0000_8888_0001;

  // Row: sr hr hw hbe[1:0] wr ww wbe[1:0] | exp scan_rdy host_rdy warp_rdy
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    12'b1_1_0_00_0_0_00_1_0_0,  // 0 scanner slot, host waits      R3 R4
    12'b0_1_0_00_0_0_00_0_1_0,  // 1 host alone                     R5
    12'b0_0_0_00_1_1_11_0_0_0,  // 2 scanner idle slot, warp waits  R4
    12'b0_0_0_00_1_1_11_0_0_1,  // 3 warp write                     R5 R11
    12'b1_1_0_00_1_0_00_1_0_0,  // 4
    12'b0_1_0_00_1_0_00_0_1_0,  // 5 contest -> host                R6
    12'b1_0_0_00_1_0_00_1_0_0,  // 6
    12'b0_1_0_00_1_0_00_0_0_1,  // 7 contest -> warp                R6
    12'b0_1_0_00_0_0_00_0_0_0,  // 8
    12'b0_1_0_00_0_0_00_0_1_0,  // 9 host read
    12'b1_1_1_10_1_0_00_1_0_0,  // 10
    12'b0_1_1_10_1_0_00_0_0_1,  // 11 contest -> warp               R6
    12'b0_1_1_10_0_0_00_0_0_0,  // 12
    12'b0_1_1_10_0_0_00_0_1_0,  // 13 host upper-lane write         R7
    12'b1_0_0_00_0_0_00_1_0_0,  // 14
    12'b0_0_0_00_0_0_00_0_0_0   // 15 idle shared slot              R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_slot, scan_req, scan_rdy, scan_rvalid;
  logic [AW-1:0] scan_addr;
  logic [DW-1:0] scan_rdata;
  logic host_req, host_we, host_rdy, host_rvalid;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic [LN-1:0] host_be;
  logic warp_req, warp_we, warp_rdy, warp_rvalid;
  logic [AW-1:0] warp_addr;
  logic [DW-1:0] warp_wdata, warp_rdata;
  logic [LN-1:0] warp_be;
  logic mem_en;
  logic [LN-1:0] mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fb_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW), .LANES(LN)) i_fb_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .scan_slot(scan_slot),
    .scan_req(scan_req), .scan_addr(scan_addr), .scan_rdy(scan_rdy),
    .scan_rvalid(scan_rvalid), .scan_rdata(scan_rdata),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be), .host_rdy(host_rdy),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .warp_req(warp_req), .warp_we(warp_we), .warp_addr(warp_addr),
    .warp_wdata(warp_wdata), .warp_be(warp_be), .warp_rdy(warp_rdy),
    .warp_rvalid(warp_rvalid), .warp_rdata(warp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_word(input int a);
    return {32'hF00D_0000 | 32'(a), 32'hBEEF_0000 | 32'(a)};
  endfunction

  // Environment: two-bank synchronous RAM, one-cycle read latency.
  logic [DW-1:0] ram [16];
  logic [DW-1:0] exp_mem [16];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we == '0) mem_rdata <= ram[mem_addr[3:0]];
      if (mem_we[0]) ram[mem_addr[3:0]][31:0]  <= mem_wdata[31:0];
      if (mem_we[1]) ram[mem_addr[3:0]][63:32] <= mem_wdata[63:32];
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic p_s, p_h, p_w;
    logic [DW-1:0] e_s, e_h, e_w;
    for (int a = 0; a < 16; a++) begin
      ram[a] = init_word(a);
      exp_mem[a] = init_word(a);
    end
    scan_req = 0; scan_addr = '0;
    host_req = 0; host_we = 0; host_addr = HOST_A; host_wdata = HOST_D; host_be = '0;
    warp_req = 0; warp_we = 0; warp_addr = WARP_A; warp_wdata = WARP_D; warp_be = '0;
    p_s = 0; p_h = 0; p_w = 0; e_s = '0; e_h = '0; e_w = '0;

    // R1: quiet during reset
    repeat (3) @(posedge clk);
    scan_req = 1; host_req = 1;
    #1;
    check("R1 rdy in reset", {61'd0, scan_rdy, host_rdy, warp_rdy}, '0);
    check("R1 mem_en in reset", {63'd0, mem_en}, '0);
    scan_req = 0; host_req = 0;
    @(posedge clk); #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      @(negedge clk);
      // returns from the previous row (R8, R9, R11)
      check($sformatf("R9 scan_rvalid row %0d", i), {63'd0, scan_rvalid}, {63'd0, p_s});
      check($sformatf("R8 host_rvalid row %0d", i), {63'd0, host_rvalid}, {63'd0, p_h});
      check($sformatf("R8 warp_rvalid row %0d", i), {63'd0, warp_rvalid}, {63'd0, p_w});
      if (p_s) check("R9 scan_rdata", scan_rdata, e_s);
      if (p_h) check("R8 host_rdata", host_rdata, e_h);
      if (p_w) check("R8 warp_rdata", warp_rdata, e_w);
      if (!p_h) check("R8 host_rdata idle", host_rdata, '0);
      check($sformatf("R2 scan_slot row %0d", i), {63'd0, scan_slot}, {63'd0, (i % 2) == 0});
      scan_req = v[11]; scan_addr = AW'(i);
      host_req = v[10]; host_we = v[9]; host_be = v[8:7];
      warp_req = v[6]; warp_we = v[5]; warp_be = v[4:3];
      #1;
      check($sformatf("R3 R5 R6 ready row %0d", i), {61'd0, scan_rdy, host_rdy, warp_rdy}, {61'd0, v[2:0]});
      check($sformatf("R4 R10 mem_en row %0d", i), {63'd0, mem_en}, {63'd0, |v[2:0]});
      if (v[2]) check("R3 mem_addr", {46'd0, mem_addr}, {46'd0, AW'(i)});
      if (v[1]) check("R5 mem_addr host", {46'd0, mem_addr}, {46'd0, HOST_A});
      if (v[0]) check("R5 mem_addr warp", {46'd0, mem_addr}, {46'd0, WARP_A});
      if (v[1] && v[9]) check("R7 mem_we", {62'd0, mem_we}, {62'd0, v[8:7]});
      // expected returns for next row
      p_s = v[2]; p_h = v[1] & ~v[9]; p_w = v[0] & ~v[5];
      e_s = exp_mem[i % 16]; e_h = exp_mem[HOST_A]; e_w = exp_mem[WARP_A];
      if (v[1] && v[9]) begin
        if (v[7]) exp_mem[HOST_A][31:0]  = HOST_D[31:0];
        if (v[8]) exp_mem[HOST_A][63:32] = HOST_D[63:32];
      end
      if (v[0] && v[5]) begin
        if (v[3]) exp_mem[WARP_A][31:0]  = WARP_D[31:0];
        if (v[4]) exp_mem[WARP_A][63:32] = WARP_D[63:32];
      end
    end
    scan_req = 0; host_req = 0; warp_req = 0;
    @(negedge clk);
    check("R11 no valid after host write", {62'd0, host_rvalid, warp_rvalid}, '0);

    // R7: readback of host word after an upper-lane-only write
    while (scan_slot) @(negedge clk);
    host_req = 1; host_we = 0;
    #1;
    check("R5 host read granted", {63'd0, host_rdy}, 64'd1);
    @(negedge clk);
    host_req = 0;
    check("R8 host_rvalid readback", {63'd0, host_rvalid}, 64'd1);
    check("R7 lower lane kept, upper written", host_rdata, 64'hABCD_1111_BEEF_0003);
    check("R8 warp quiet on host read", {63'd0, warp_rvalid}, '0);

    // R1: reset mid-run, then first slot is the scanner's
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rvalid cleared", {61'd0, scan_rvalid, host_rvalid, warp_rvalid}, '0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 first slot scanner", {63'd0, scan_slot}, 64'd1);
    @(negedge clk);
    check("R2 next slot shared", {63'd0, scan_slot}, '0);
    // R6: after reset, host wins the first contest
    host_req = 1; warp_req = 1;
    #1;
    check("R6 host first after reset", {62'd0, host_rdy, warp_rdy}, 64'd2);
    @(negedge clk);
    host_req = 0;
    @(negedge clk);
    #1;
    check("R6 warp next", {62'd0, host_rdy, warp_rdy}, 64'd1);
    warp_req = 0;

    done = 1'b1;
    finish_run();
  end
endmodule